// File: doc/BRIEF.md
# Per-Master Address Decoder with Boot Remap

This block turns one bus master's address into the index of the slave port that should carry the access. It also checks whether that master may use that slave. One copy sits beside every master. All copies share the same address map. The only per-copy input is the master number on `master_id_i`, so one module serves all masters.

The lowest address window is the boot window. Its target depends on two things:

- A non-volatile strap captured while reset is held. It selects on-chip ROM or the external memory on chip select 0.
- A run-time remap flag. Once set, it places on-chip SRAM in the boot window, so exception vectors can be rewritten.

The DDR window is spread over four DDR ports according to the master number and a video-mode input. Some paths are not allowed. Unmapped addresses are also not allowed. In both cases the decoder raises an error flag and drives no selection.

Top module: `adec_master_decode`

Slave index encoding used throughout: 0 on-chip SRAM, 1 on-chip ROM (with peripheral RAMs), 2 DDR port 0, 3 DDR port 1, 4 DDR port 2, 5 DDR port 3, 6 external memory controller, 7 on-chip peripherals.

Address windows are decoded from `addr_i[31:28]`:

| `addr_i[31:28]` | Window |
|---|---|
| 0x0 | boot window |
| 0x1 | ROM alias |
| 0x3 | SRAM |
| 0x6 | external memory |
| 0x7 | DDR |
| 0xF | peripherals |
| any other value | unmapped |

Master numbers: 0 CPU instruction, 1 CPU data, 2 peripheral transfer engine, 7 display DMA, 8 network DMA, 11 video decoder. Valid master numbers are 0 to 11.

## Requirements
- R1: With strap 0 captured at reset and remap clear, a valid boot-window access selects slave 1.
- R2: With strap 1 captured at reset and remap clear, a valid boot-window access selects slave 6.
- R3: The strap is sampled on every clock edge while `rst_n` is low, and the last sample is kept. Changes of `boot_strap_i` after reset release have no effect on the boot-window selection.
- R4: A `remap_set_i` pulse takes effect on the next clock edge: from then on, boot-window accesses select slave 0. The ROM alias window keeps selecting slave 1.
- R5: `remap_clr_i` clears the remap flag on the next edge, and reset also clears it. When set and clear arrive together, clear wins.
- R6: The fixed windows select as follows: ROM alias → 1, SRAM → 0, external memory → 6, peripherals → 7.
- R7: In the DDR window with `video_mode_i` = 0:
  - master 0 selects slave 2;
  - master 1 selects slave 3;
  - every other master selects slave 4 if its number is even and slave 5 if it is odd.
- R8: In the DDR window with `video_mode_i` = 1:
  - master 11 selects slave 2;
  - master 7 selects slave 3;
  - every other master selects slave 4 if its number is even and slave 5 if it is odd.
- R9: Only masters 0, 1 and 2 may reach the peripherals. Any other master raises `path_err_o`, with `sel_vld_o` = 0 and `slave_sel_o` = 0. Master 8 is an example.
- R10: An unmapped window, or a master number of 12 or more, raises `path_err_o` with no selection.
- R11: With `valid_i` low, all three outputs are 0 regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| boot_strap_i | input | 1 | Non-volatile boot selector: 0 selects ROM, 1 selects external memory |
| remap_set_i | input | 1 | One-cycle request to put SRAM in the boot window |
| remap_clr_i | input | 1 | One-cycle request to undo the remap |
| video_mode_i | input | 1 | Video-mode DDR port assignment |
| valid_i | input | 1 | Address is valid this cycle |
| master_id_i | input | 4 | Number of the master issuing the address |
| addr_i | input | 32 | Access address |
| slave_sel_o | output | 3 | Selected slave index |
| sel_vld_o | output | 1 | Selection is valid |
| path_err_o | output | 1 | Forbidden path or unmapped address |

## Verification
The hardest state to reach from the ports is the combination of external-memory boot and remap. This is where SRAM must override a strap captured earlier. Reaching it means driving the strap high only while reset is held, then lowering it after release, and only then pulsing the remap request. The bench then checks that the boot window falls back to external memory, not ROM, once the remap is cleared. The set-and-clear collision and a reset issued while remapped are both driven in the same sequence.

// File: rtl/adec_pkg.sv
// Shared types for the per-master address decoder.
// Assumes eight slave ports and a window tag taken from the top address bits.
package adec_pkg;

    localparam int SLV_W = 3;

    // Slave port numbering; the values are the slave_sel_o encoding.
    typedef enum logic [SLV_W-1:0] {
        SLV_SRAM   = 3'd0,
        SLV_ROM    = 3'd1,
        SLV_DDR0   = 3'd2,
        SLV_DDR1   = 3'd3,
        SLV_DDR2   = 3'd4,
        SLV_DDR3   = 3'd5,
        SLV_XMEM   = 3'd6,
        SLV_PERIPH = 3'd7
    } slave_e;

    // Decoded address windows.
    typedef enum logic [2:0] {
        WIN_BOOT,
        WIN_ROM,
        WIN_SRAM,
        WIN_XMEM,
        WIN_DDR,
        WIN_PERIPH,
        WIN_NONE
    } window_e;

endpackage

// File: rtl/adec_boot_ctrl.sv
// Boot state holder: captures the non-volatile boot strap while reset is low
// and keeps the remap flag. Assumes set/clear requests are single-cycle pulses.
module adec_boot_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_strap_i,
    input  logic remap_set_i,
    input  logic remap_clr_i,
    output logic boot_ext_o,
    output logic remap_o
);

    logic boot_ext_q;
    logic remap_q;

    // Strap capture: follow the strap during reset, hold after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_ext_q <= boot_strap_i;
        end
    end

    // Remap flag: clear has priority over set; reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
        end else if (remap_clr_i) begin
            remap_q <= 1'b0;
        end else if (remap_set_i) begin
            remap_q <= 1'b1;
        end
    end

    assign boot_ext_o = boot_ext_q;
    assign remap_o    = remap_q;

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_ext_q)); // R3

    AST_REMAP_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        remap_clr_i |=> !remap_q); // R5

    AST_REMAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_set_i && !remap_clr_i) |=> remap_q); // R4

endmodule

// File: rtl/adec_window_map.sv
// Window decoder: classifies an address by its top TAG_W bits.
// Assumes every window is aligned to a tag boundary.
module adec_window_map
    import adec_pkg::*;
#(
    parameter int              AW       = 32,
    parameter int              TAG_W    = 4,
    parameter logic [TAG_W-1:0] TAG_BOOT = 4'h0,
    parameter logic [TAG_W-1:0] TAG_ROM  = 4'h1,
    parameter logic [TAG_W-1:0] TAG_SRAM = 4'h3,
    parameter logic [TAG_W-1:0] TAG_XMEM = 4'h6,
    parameter logic [TAG_W-1:0] TAG_DDR  = 4'h7,
    parameter logic [TAG_W-1:0] TAG_PERI = 4'hF
) (
    input  logic [AW-1:0] addr_i,
    output window_e       win_o
);

    localparam int TAG_LSB = AW - TAG_W;

    logic [TAG_W-1:0] tag;
    assign tag = addr_i[AW-1:TAG_LSB];

    // Tag compare: one window per tag value, the rest unmapped.
    always_comb begin
        if (tag == TAG_BOOT)      win_o = WIN_BOOT;
        else if (tag == TAG_ROM)  win_o = WIN_ROM;
        else if (tag == TAG_SRAM) win_o = WIN_SRAM;
        else if (tag == TAG_XMEM) win_o = WIN_XMEM;
        else if (tag == TAG_DDR)  win_o = WIN_DDR;
        else if (tag == TAG_PERI) win_o = WIN_PERIPH;
        else                      win_o = WIN_NONE;
    end

endmodule

// File: rtl/adec_ddr_steer.sv
// DDR port steering: picks one of four DDR ports from master number and
// video mode. Assumes the two dedicated-port pairs are fixed master numbers.
module adec_ddr_steer
    import adec_pkg::*;
#(
    parameter int MIDW     = 4,
    parameter int CPU_I_ID = 0,
    parameter int CPU_D_ID = 1,
    parameter int DISP_ID  = 7,
    parameter int VDEC_ID  = 11
) (
    input  logic [MIDW-1:0] master_id_i,
    input  logic            video_mode_i,
    output slave_e          port_o
);

    localparam logic [MIDW-1:0] ID_CI = MIDW'(CPU_I_ID);
    localparam logic [MIDW-1:0] ID_CD = MIDW'(CPU_D_ID);
    localparam logic [MIDW-1:0] ID_DP = MIDW'(DISP_ID);
    localparam logic [MIDW-1:0] ID_VD = MIDW'(VDEC_ID);

    slave_e shared_port;

    // Shared ports: even numbers to port 2, odd to port 3.
    assign shared_port = master_id_i[0] ? SLV_DDR3 : SLV_DDR2;

    // Dedicated port selection by mode.
    always_comb begin
        port_o = shared_port;
        if (!video_mode_i) begin
            if (master_id_i == ID_CI)      port_o = SLV_DDR0;
            else if (master_id_i == ID_CD) port_o = SLV_DDR1;
        end else begin
            if (master_id_i == ID_VD)      port_o = SLV_DDR0;
            else if (master_id_i == ID_DP) port_o = SLV_DDR1;
        end
    end

endmodule

// File: rtl/adec_path_check.sv
// Access permission check: flags master numbers out of range and masters
// without permission to the peripheral slave. Assumes all other paths open.
module adec_path_check
    import adec_pkg::*;
#(
    parameter int                  MIDW      = 4,
    parameter int                  N_MASTERS = 12,
    parameter logic [N_MASTERS-1:0] PERI_OK  = 12'h007
) (
    input  logic [MIDW-1:0] master_id_i,
    input  slave_e          slave_i,
    output logic            forbid_o
);

    localparam int ID_SPACE = 2 ** MIDW;

    logic [ID_SPACE-1:0] id_known;
    logic [ID_SPACE-1:0] peri_allow;

    // Expand the per-master masks over the whole number space.
    for (genvar g = 0; g < ID_SPACE; g++) begin : g_mask
        if (g < N_MASTERS) begin : g_in
            assign id_known[g]   = 1'b1;
            assign peri_allow[g] = PERI_OK[g];
        end else begin : g_out
            assign id_known[g]   = 1'b0;
            assign peri_allow[g] = 1'b0;
        end
    end

    // Forbid unknown masters and unlisted peripheral access.
    always_comb begin
        forbid_o = !id_known[master_id_i];
        if (slave_i == SLV_PERIPH && !peri_allow[master_id_i]) begin
            forbid_o = 1'b1;
        end
    end

endmodule

// File: rtl/adec_master_decode.sv
// Per-master address decoder top: window decode, boot routing with remap,
// DDR steering and permission check. Outputs are combinational from the
// address and the registered boot/remap state.
module adec_master_decode
    import adec_pkg::*;
#(
    parameter int                  AW        = 32,
    parameter int                  N_MASTERS = 12,
    parameter int                  MIDW      = 4,
    parameter logic [N_MASTERS-1:0] PERI_OK  = 12'h007
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_strap_i,
    input  logic             remap_set_i,
    input  logic             remap_clr_i,
    input  logic             video_mode_i,
    input  logic             valid_i,
    input  logic [MIDW-1:0]  master_id_i,
    input  logic [AW-1:0]    addr_i,
    output logic [SLV_W-1:0] slave_sel_o,
    output logic             sel_vld_o,
    output logic             path_err_o
);

    logic    boot_ext;
    logic    remap;
    window_e win;
    slave_e  ddr_port;
    slave_e  boot_slave;
    slave_e  cand;
    logic    unmapped;
    logic    forbid;
    logic    err;

    adec_boot_ctrl u_boot (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_strap_i (boot_strap_i),
        .remap_set_i  (remap_set_i),
        .remap_clr_i  (remap_clr_i),
        .boot_ext_o   (boot_ext),
        .remap_o      (remap)
    );

    adec_window_map #(.AW(AW)) u_win (
        .addr_i (addr_i),
        .win_o  (win)
    );

    adec_ddr_steer #(.MIDW(MIDW)) u_ddr (
        .master_id_i  (master_id_i),
        .video_mode_i (video_mode_i),
        .port_o       (ddr_port)
    );

    // Boot window target: remap first, then the captured strap.
    always_comb begin
        if (remap)         boot_slave = SLV_SRAM;
        else if (boot_ext) boot_slave = SLV_XMEM;
        else               boot_slave = SLV_ROM;
    end

    // Candidate slave per window.
    always_comb begin
        unmapped = 1'b0;
        unique case (win)
            WIN_BOOT:   cand = boot_slave;
            WIN_ROM:    cand = SLV_ROM;
            WIN_SRAM:   cand = SLV_SRAM;
            WIN_XMEM:   cand = SLV_XMEM;
            WIN_DDR:    cand = ddr_port;
            WIN_PERIPH: cand = SLV_PERIPH;
            default: begin
                cand     = SLV_SRAM;
                unmapped = 1'b1;
            end
        endcase
    end

    adec_path_check #(
        .MIDW      (MIDW),
        .N_MASTERS (N_MASTERS),
        .PERI_OK   (PERI_OK)
    ) u_chk (
        .master_id_i (master_id_i),
        .slave_i     (cand),
        .forbid_o    (forbid)
    );

    // Output gating: error or idle drives no selection.
    assign err         = valid_i && (unmapped || forbid);
    assign path_err_o  = err;
    assign sel_vld_o   = valid_i && !err;
    assign slave_sel_o = sel_vld_o ? cand : '0;

    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        path_err_o |-> (!sel_vld_o && slave_sel_o == '0)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (!sel_vld_o && !path_err_o)); // R11

    AST_REMAP_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (remap && win == WIN_BOOT && sel_vld_o) |-> slave_sel_o == SLV_SRAM); // R4

    AST_VDEC_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && video_mode_i && win == WIN_DDR && master_id_i == MIDW'(11))
        |-> slave_sel_o == SLV_DDR0); // R8

    AST_NET_NO_PERI: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && win == WIN_PERIPH && master_id_i == MIDW'(8)) |-> path_err_o); // R9

endmodule

// File: tb/tb_adec_master_decode.sv
module tb_adec_master_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_strap_i = 1'b0;
    logic        remap_set_i = 1'b0;
    logic        remap_clr_i = 1'b0;
    logic        video_mode_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  master_id_i = '0;
    logic [31:0] addr_i = '0;
    logic [2:0]  slave_sel_o;
    logic        sel_vld_o;
    logic        path_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    adec_master_decode dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_strap_i (boot_strap_i),
        .remap_set_i  (remap_set_i),
        .remap_clr_i  (remap_clr_i),
        .video_mode_i (video_mode_i),
        .valid_i      (valid_i),
        .master_id_i  (master_id_i),
        .addr_i       (addr_i),
        .slave_sel_o  (slave_sel_o),
        .sel_vld_o    (sel_vld_o),
        .path_err_o   (path_err_o)
    );

    task automatic expect3(string req, logic [2:0] es, logic ev, logic ee);
        n_chk++;
        if (slave_sel_o !== es || sel_vld_o !== ev || path_err_o !== ee) begin
            n_bad++;
            $display("FAIL %s: sel/vld/err = %0d/%0d/%0d, expected %0d/%0d/%0d",
                     req, slave_sel_o, sel_vld_o, path_err_o, es, ev, ee);
        end
    endtask

    // Apply an access at a falling edge, then sample 1 ns later.
    task automatic probe(string req, logic [3:0] m, logic [31:0] a,
                         logic [2:0] es, logic ev, logic ee);
        @(negedge clk);
        valid_i = 1'b1; master_id_i = m; addr_i = a;
        #1;
        expect3(req, es, ev, ee);
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0; boot_strap_i = strap; valid_i = 1'b0;
        remap_set_i = 1'b0; remap_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(logic s, logic c);
        @(negedge clk);
        remap_set_i = s; remap_clr_i = c;
        @(negedge clk);
        remap_set_i = 1'b0; remap_clr_i = 1'b0;
    endtask

    function automatic logic [2:0] ddr_exp(int m, bit vid);
        if (!vid && m == 0) return 3'd2;
        if (!vid && m == 1) return 3'd3;
        if (vid && m == 11) return 3'd2;
        if (vid && m == 7)  return 3'd3;
        return (m % 2 == 1) ? 3'd5 : 3'd4;
    endfunction

    task automatic t_reset_rom;
        do_reset(1'b0);
        #1; expect3("R11 reset idle", 3'd0, 1'b0, 1'b0);
        probe("R1 rom boot", 4'd0, 32'h0000_0040, 3'd1, 1'b1, 1'b0);
        probe("R1 rom boot m5", 4'd5, 32'h0FFF_FFFC, 3'd1, 1'b1, 1'b0);
    endtask

    task automatic t_strap_frozen;
        @(negedge clk); boot_strap_i = 1'b1;
        repeat (2) @(negedge clk);
        probe("R3 strap ignored after release", 4'd1, 32'h0000_0000, 3'd1, 1'b1, 1'b0);
        do_reset(1'b1);
        probe("R2 external boot", 4'd0, 32'h0000_1000, 3'd6, 1'b1, 1'b0);
        @(negedge clk); boot_strap_i = 1'b0;
        repeat (2) @(negedge clk);
        probe("R3 strap low ignored", 4'd0, 32'h0000_1000, 3'd6, 1'b1, 1'b0);
    endtask

    task automatic t_remap;
        pulse(1'b1, 1'b0);
        probe("R4 remap to sram", 4'd0, 32'h0000_0000, 3'd0, 1'b1, 1'b0);
        probe("R4 rom alias kept", 4'd0, 32'h1000_0000, 3'd1, 1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        probe("R5 clear back to external", 4'd0, 32'h0000_0000, 3'd6, 1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        probe("R5 clear wins", 4'd0, 32'h0000_0000, 3'd6, 1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        do_reset(1'b0);
        probe("R5 reset clears remap", 4'd0, 32'h0000_0000, 3'd1, 1'b1, 1'b0);
    endtask

    task automatic t_fixed;
        probe("R6 rom alias", 4'd3, 32'h1234_5678, 3'd1, 1'b1, 1'b0);
        probe("R6 sram", 4'd3, 32'h3000_0100, 3'd0, 1'b1, 1'b0);
        probe("R6 external", 4'd9, 32'h6ABC_0000, 3'd6, 1'b1, 1'b0);
        probe("R6 peripherals", 4'd1, 32'hFFFF_F000, 3'd7, 1'b1, 1'b0);
    endtask

    task automatic t_ddr(bit vid);
        @(negedge clk); video_mode_i = vid;
        for (int m = 0; m < 12; m++) begin
            probe(vid ? "R8 ddr video" : "R7 ddr normal", 4'(m),
                  32'h7000_0000 + 32'(m), ddr_exp(m, vid), 1'b1, 1'b0);
        end
        @(negedge clk); video_mode_i = 1'b0;
    endtask

    task automatic t_forbid;
        probe("R9 network to peripherals", 4'd8, 32'hF000_0000, 3'd0, 1'b0, 1'b1);
        probe("R9 video to peripherals", 4'd11, 32'hF000_0004, 3'd0, 1'b0, 1'b1);
        probe("R9 transfer engine allowed", 4'd2, 32'hF000_0000, 3'd7, 1'b1, 1'b0);
        probe("R9 network to ddr allowed", 4'd8, 32'h7000_0000, 3'd4, 1'b1, 1'b0);
    endtask

    task automatic t_invalid;
        probe("R10 unmapped window", 4'd0, 32'h5000_0000, 3'd0, 1'b0, 1'b1);
        probe("R10 unmapped window 2", 4'd1, 32'h2000_0000, 3'd0, 1'b0, 1'b1);
        probe("R10 master 12", 4'd12, 32'h3000_0000, 3'd0, 1'b0, 1'b1);
        probe("R10 master 15", 4'd15, 32'h7000_0000, 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        valid_i = 1'b0; master_id_i = 4'd8; addr_i = 32'hF000_0000;
        #1; expect3("R11 idle forbidden", 3'd0, 1'b0, 1'b0);
        addr_i = 32'h7000_0000;
        #1; expect3("R11 idle ddr", 3'd0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset_rom();
        t_fixed();
        t_strap_frozen();
        t_remap();
        t_ddr(1'b0);
        t_ddr(1'b1);
        t_forbid();
        t_invalid();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule